// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This unit applies one-bit operations to a destination byte. It can combine a chosen bit of one operand with bit 0 of the other operand using AND, OR or XOR. It can also compare two such bits, and it can complement, set or clear one bit of the destination. A three-bit index selects the bit. A direction input chooses the pairing. In the forward pairing, destination bit 0 is combined with source bit `idx`. In the reverse pairing, destination bit `idx` is combined with source bit 0. The unit returns the new destination byte, a zero flag, sign and overflow flags (both driven low), and separate write strobes for the byte and for the flags. A surrounding datapath uses these strobes to decide what to store back.

A request is a one-cycle `start` pulse. On that clock edge the operands are captured, and the outputs are produced by a registered stage. A two-state controller sequences each request:

- `ST_IDLE` means no result is being presented.
- `ST_DONE` means a result is presented for one cycle.

The controller has three transitions:

- `T_ACCEPT`: from `ST_IDLE` to `ST_DONE`, on `start`.
- `T_CHAIN`: from `ST_DONE` to `ST_DONE`, on `start`, which gives back-to-back requests.
- `T_RETIRE`: from `ST_DONE` to `ST_IDLE`, when `start` is low.

The result byte and zero flag hold their values until the next request. The write strobes are raised only in `ST_DONE`.

Top module: `bitu_top`

## Requirements
- R1: After reset, `done`, `result_we` and `flags_we` are 0, and `result` and `z_flag` are 0.
- R2: Operation codes 0 (AND), 1 (OR) and 2 (XOR) with `dir`=0 write `dst[0] op src[idx]` into bit 0 of `result`.
- R3: Operation codes 0, 1 and 2 with `dir`=1 write `dst[idx] op src[0]` into bit `idx` of `result`.
- R4: No operation changes any bit of `result` other than its target bit, compared with the captured destination byte.
- R5: For codes 0, 1, 2 and 4, `result_we`=1 and `flags_we`=1, and `z_flag` is the inverse of the new target bit.
- R6: Code 3 (compare) leaves `result` equal to the destination, sets `result_we`=0 and `flags_we`=1. It sets `z_flag`=1 when the paired bits are equal: `dst[0]` with `src[idx]` for `dir`=0, or `dst[idx]` with `src[0]` for `dir`=1.
- R7: Code 4 inverts `dst[idx]`, code 5 sets it and code 6 clears it. For these codes `src` and `dir` have no effect.
- R8: Codes 5 and 6 give `flags_we`=0, `z_flag`=0 and `result_we`=1.
- R9: `s_flag` and `v_flag` are always 0.
- R10: Code 7 is reserved. It gives `result_we`=0, `flags_we`=0, `z_flag`=0 and `result` equal to the destination.
- R11: `done` is 1 in the cycle after a clock edge that samples `start`=1, and is 0 otherwise. `result` and `z_flag` hold until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe; operands are sampled on this edge |
| op | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 compare, 4 complement, 5 set, 6 clear, 7 reserved) |
| dir | input | 1 | Pairing: 0 = dst bit 0 with src bit idx, 1 = dst bit idx with src bit 0 |
| bit_idx | input | 3 | Selected bit position |
| dst_in | input | 8 | Destination byte |
| src_in | input | 8 | Source byte |
| done | output | 1 | Result presented this cycle |
| result | output | 8 | New destination byte |
| result_we | output | 1 | Store `result` into the destination |
| flags_we | output | 1 | Store the flag outputs |
| z_flag | output | 1 | Zero / equality flag |
| s_flag | output | 1 | Sign flag, always 0 |
| v_flag | output | 1 | Overflow flag, always 0 |

## Verification
Every result passes through exactly one register. The values sampled on the clock edge where `start` is high therefore appear in the following cycle, alongside `done`. The bench drives each request on a falling edge and holds `start` across one rising edge. It compares all outputs at the next falling edge, which is mid-way through the cycle in which the result is due. The retire path is checked one further falling edge later: `done` and the strobes must be low, and `result` must be unchanged.

// File: rtl/bitu_pkg.sv
package bitu_pkg;

    typedef enum logic [2:0] {
        OP_AND   = 3'd0,
        OP_OR    = 3'd1,
        OP_XOR   = 3'd2,
        OP_CMP   = 3'd3,
        OP_FLIP  = 3'd4,
        OP_SET   = 3'd5,
        OP_CLR   = 3'd6,
        OP_RSV   = 3'd7
    } bitu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } bitu_state_e;

endpackage

// File: rtl/bitu_pick.sv
module bitu_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] idx,
    output logic          bit_out
);

    always_comb begin
        bit_out = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx == IW'(i)) begin
                bit_out = vec[i];
            end
        end
    end

endmodule

// File: rtl/bitu_place.sv
module bitu_place #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [W-1:0]  vec_out
);

    for (genvar g = 0; g < W; g++) begin : g_lane
        assign vec_out[g] = (idx == IW'(g)) ? bit_in : vec[g];
    end

endmodule

// File: rtl/bitu_alu.sv
module bitu_alu
    import bitu_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  dst,
    input  logic [W-1:0]  src,
    input  logic [IW-1:0] idx,
    input  bitu_op_e      op,
    input  logic          dir,
    output logic [W-1:0]  res,
    output logic          res_we,
    output logic          flag_we,
    output logic          z
);

    logic          dst_sel;
    logic          src_sel;
    logic          lhs;
    logic          rhs;
    logic          new_bit;
    logic [IW-1:0] tgt;
    logic [W-1:0]  placed;
    logic          use_placed;

    bitu_pick #(.W(W), .IW(IW)) u_pick_dst (.vec(dst), .idx(idx), .bit_out(dst_sel));
    bitu_pick #(.W(W), .IW(IW)) u_pick_src (.vec(src), .idx(idx), .bit_out(src_sel));

    // pairing chosen by direction
    assign lhs = dir ? dst_sel : dst[0];
    assign rhs = dir ? src[0]  : src_sel;

    bitu_place #(.W(W), .IW(IW)) u_place (
        .vec    (dst),
        .idx    (tgt),
        .bit_in (new_bit),
        .vec_out(placed)
    );

    always_comb begin
        tgt        = dir ? idx : '0;
        new_bit    = 1'b0;
        use_placed = 1'b0;
        res_we     = 1'b0;
        flag_we    = 1'b0;
        z          = 1'b0;
        unique case (op)
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)      new_bit = lhs & rhs;
                else if (op == OP_OR)  new_bit = lhs | rhs;
                else                   new_bit = lhs ^ rhs;
                use_placed = 1'b1;
                res_we     = 1'b1;
                flag_we    = 1'b1;
                z          = ~new_bit;
            end
            OP_CMP: begin
                flag_we = 1'b1;
                z       = (lhs == rhs);
            end
            OP_FLIP: begin
                tgt        = idx;
                new_bit    = ~dst_sel;
                use_placed = 1'b1;
                res_we     = 1'b1;
                flag_we    = 1'b1;
                z          = dst_sel;
            end
            OP_SET, OP_CLR: begin
                tgt        = idx;
                new_bit    = (op == OP_SET);
                use_placed = 1'b1;
                res_we     = 1'b1;
            end
            default: begin
                // reserved code: nothing written
            end
        endcase
        res = use_placed ? placed : dst;
    end

endmodule

// File: rtl/bitu_top.sv
module bitu_top
    import bitu_pkg::*;
#(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic          dir,
    input  logic [IW-1:0] bit_idx,
    input  logic [W-1:0]  dst_in,
    input  logic [W-1:0]  src_in,
    output logic          done,
    output logic [W-1:0]  result,
    output logic          result_we,
    output logic          flags_we,
    output logic          z_flag,
    output logic          s_flag,
    output logic          v_flag
);

    bitu_state_e state_q;
    bitu_state_e state_d;

    logic [W-1:0] alu_res;
    logic         alu_res_we;
    logic         alu_flag_we;
    logic         alu_z;

    logic [W-1:0] res_q;
    logic         res_we_q;
    logic         flag_we_q;
    logic         z_q;

    bitu_alu #(.W(W), .IW(IW)) u_alu (
        .dst    (dst_in),
        .src    (src_in),
        .idx    (bit_idx),
        .op     (bitu_op_e'(op)),
        .dir    (dir),
        .res    (alu_res),
        .res_we (alu_res_we),
        .flag_we(alu_flag_we),
        .z      (alu_z)
    );

    // transitions: T_ACCEPT, T_CHAIN, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_we_q  <= 1'b0;
            flag_we_q <= 1'b0;
            z_q       <= 1'b0;
        end else if (start) begin
            res_q     <= alu_res;
            res_we_q  <= alu_res_we;
            flag_we_q <= alu_flag_we;
            z_q       <= alu_z;
        end
    end

    assign done      = (state_q == ST_DONE);
    assign result    = res_q;
    assign result_we = res_we_q & done;
    assign flags_we  = flag_we_q & done;
    assign z_flag    = z_q;
    assign s_flag    = 1'b0;
    assign v_flag    = 1'b0;

endmodule

// File: rtl/bitu_chk.sv
module bitu_chk #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    op,
    input logic [W-1:0]  dst_in,
    input logic          done,
    input logic [W-1:0]  result,
    input logic          result_we,
    input logic          flags_we,
    input logic          z_flag
);

    a_r11_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r11_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

    a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ($countones(result ^ $past(dst_in)) <= 1));

    a_r6_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd3) |=> (!result_we && flags_we && result == $past(dst_in)));

    a_r8_setclr_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 3'd5 || op == 3'd6)) |=> (!flags_we && result_we && !z_flag));

    a_r10_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd7) |=> (!result_we && !flags_we && result == $past(dst_in)));

endmodule

bind bitu_top bitu_chk #(.W(W), .IW(IW)) u_bitu_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .dst_in   (dst_in),
    .done     (done),
    .result   (result),
    .result_we(result_we),
    .flags_we (flags_we),
    .z_flag   (z_flag)
);

// File: tb/test_bitu_top.sv
module test_bitu_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = '0;
    logic       dir = 1'b0;
    logic [2:0] bit_idx = '0;
    logic [7:0] dst_in = '0;
    logic [7:0] src_in = '0;
    logic       done;
    logic [7:0] result;
    logic       result_we;
    logic       flags_we;
    logic       z_flag;
    logic       s_flag;
    logic       v_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bitu_top i_bitu_top (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dir(dir),
        .bit_idx(bit_idx), .dst_in(dst_in), .src_in(src_in), .done(done),
        .result(result), .result_we(result_we), .flags_we(flags_we),
        .z_flag(z_flag), .s_flag(s_flag), .v_flag(v_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic dr);
        case (o)
            3'd0, 3'd1, 3'd2: return dr ? "R3" : "R2";
            3'd3:             return "R6";
            3'd4:             return "R7";
            3'd5, 3'd6:       return "R8";
            default:          return "R10";
        endcase
    endfunction

    // issue one request and check it in the cycle it is due
    task automatic run(input logic [2:0] o, input logic dr, input logic [2:0] b,
                       input logic [7:0] d, input logic [7:0] s);
        logic [7:0] e_res;
        logic e_rwe, e_fwe, e_z, a, bb, nb;
        logic [2:0] t;
        e_res = d; e_rwe = 0; e_fwe = 0; e_z = 0;
        a  = dr ? d[b] : d[0];
        bb = dr ? s[0] : s[b];
        t  = dr ? b : 3'd0;
        case (o)
            3'd0, 3'd1, 3'd2: begin
                nb = (o == 3'd0) ? (a & bb) : (o == 3'd1) ? (a | bb) : (a ^ bb);
                e_res[t] = nb; e_rwe = 1; e_fwe = 1; e_z = ~nb;   // R5
            end
            3'd3: begin e_fwe = 1; e_z = (a == bb); end
            3'd4: begin e_res[b] = ~d[b]; e_rwe = 1; e_fwe = 1; e_z = d[b]; end
            3'd5: begin e_res[b] = 1'b1; e_rwe = 1; end
            3'd6: begin e_res[b] = 1'b0; e_rwe = 1; end
            default: ;
        endcase
        op = o; dir = dr; bit_idx = b; dst_in = d; src_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(tag_of(o, dr), {5'd0, result, result_we, flags_we, z_flag},
              {5'd0, e_res, e_rwe, e_fwe, e_z});
        check("R9", {14'd0, s_flag, v_flag}, 16'd0);
        check("R11", {15'd0, done}, 16'd1);
        check("R4", 16'($countones(result ^ d) <= 1), 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1", {5'd0, result, result_we, flags_we, z_flag}, 16'd0);
        check("R1", {15'd0, done}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {15'd0, done}, 16'd0);

        // worked cases
        run(3'd0, 1'b0, 3'd1, 8'h07, 8'h05);
        check("R2", {8'd0, result}, 16'h0006);
        run(3'd4, 1'b0, 3'd1, 8'h07, 8'h00);
        check("R7", {8'd0, result}, 16'h0005);
        run(3'd5, 1'b1, 3'd3, 8'h07, 8'hFF);
        check("R7", {8'd0, result}, 16'h000F);

        // retire and hold
        @(negedge clk);
        check("R11", {7'd0, done, result}, 16'h000F);
        check("R11", {14'd0, result_we, flags_we}, 16'd0);

        // near-exhaustive sweep
        for (int d = 0; d < 256; d++) begin
            for (int o = 0; o < 8; o++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    for (int b = 0; b < 8; b++) begin
                        run(3'(o), 1'(dr), 3'(b), 8'(d),
                            8'(d * 29 + b * 71 + o * 5 + dr * 3));
                    end
                end
            end
        end

        @(negedge clk);
        check("R11", {15'd0, done}, 16'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule